// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a binary up-counter built from a chain of identical narrow stages. Each stage holds a small count and has a synchronous clear and a synchronous parallel load. It also has two count-enable inputs. One enable is shared by every stage. The other arrives from the previous stage's terminal-count signal, so each stage advances only when every stage below it holds all ones.

A parameter sets how many stages form the counter. The terminal count of the last stage is brought out as the carry output, so a wider counter can be built by chaining further instances. A second parameter selects a modulus mode. In that mode, a decode of the count value N-1 drives the synchronous clear on the next counting step, so the counter cycles through 0..N-1 with no glitch at the wrap.

The whole block runs in one rising-edge clock domain. A synchronous, active-high power-on reset initialises it. No input acts between clock edges, except that the carry output follows the trickle enable combinationally.

Top module: `cnt_chain`

## Requirements
- R1: With `rst` high at a rising clock edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst` low and `clr_n` low at an edge, `count` becomes 0, whatever `load_n`, `cnt_en_p` and `cnt_en_t` are.
- R3: With `rst` low, `clr_n` high and `load_n` low at an edge, `count` takes `load_val`, whatever the two enables are.
- R4: With `rst` low, `clr_n` and `load_n` high, and both `cnt_en_p` and `cnt_en_t` high, `count` increases by exactly one at the edge. The carry propagates across stage boundaries, for example 0x0F to 0x10.
- R5: With `rst` low, `clr_n` and `load_n` high, and either enable low, `count` keeps its value.
- R6: In binary mode (`MODULUS` = 0), `carry_out` is high exactly when `cnt_en_t` is high and every bit of `count` is 1. It follows `cnt_en_t` without waiting for a clock edge.
- R7: In binary mode, counting from the all-ones value gives 0.
- R8: In modulus mode (`MODULUS` = N > 0), a counting step taken while `count` equals N-1 gives 0, so a count from 0 runs 0..N-1 repeatedly. In this mode `carry_out` is `cnt_en_t` AND (`count` == N-1).
- R9: In modulus mode, the wrap happens only on a counting step. Holding at N-1 keeps N-1, and a load at N-1 takes `load_val`. A loaded value at or above N counts upward and wraps through the all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high power-on initialisation |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Count enable shared by all stages |
| cnt_en_t | input | 1 | Trickle count enable into stage 0; also gates `carry_out` |
| load_val | input | STAGES*STAGE_W | Parallel load value |
| count | output | STAGES*STAGE_W | Counter value |
| carry_out | output | 1 | Terminal-count output for cascading |

## Verification
The counter is driven with random mixes of reset, clear, load and the two enables. These mixes separate the priority order: a wrong ordering between clear and load, or between load and the enables, shows up as a miscompare against a reference model. Directed runs cover three further cases. Loading 0xFC and counting through the wrap exposes the all-ones rollover. Loading 0x0F shows whether the carry ripples into the upper stage. Toggling the trickle enable with no clock edge shows whether `carry_out` is combinational rather than registered. Two modulus instances, N=5 and N=11, run the same stimulus. They show that the wrap point is N-1, that the wrap happens only on a counting step, and how the counter recovers from loaded values above the modulus.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Operation chosen for one clock edge, highest priority first in pick_op.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Control bundle handed to each stage.
    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } cnt_ctrl_t;

    function automatic cnt_op_e pick_op(input logic init, input cnt_ctrl_t c);
        if (init || !c.clr_n)
            return OP_CLEAR;
        else if (!c.load_n)
            return OP_LOAD;
        else if (c.en_p && c.en_t)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

    function automatic logic step_taken(input cnt_ctrl_t c);
        return c.clr_n && c.load_n && c.en_p && c.en_t;
    endfunction

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctrl_t    ctrl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ONE = W'(1);

    cnt_op_e op;

    always_comb op = pick_op(rst, ctrl);

    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= d;
            OP_COUNT: q <= q + ONE;
            default:  q <= q;
        endcase
    end

    // Look-ahead terminal count: gated only by the trickle enable.
    always_comb tc = ctrl.en_t && (&q);

    // R1
    init_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.clr_n |=> (q == '0));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr_n && !ctrl.load_n) |=> (q == $past(d)));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_taken(ctrl) |=> (q == $past(q) + ONE));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr_n && ctrl.load_n && !(ctrl.en_p && ctrl.en_t)) |=> $stable(q));

endmodule

// File: rtl/cnt_mod_detect.sv
module cnt_mod_detect
    import cnt_pkg::*;
#(
    parameter int W       = 4,
    parameter int MODULUS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctrl_t    ctrl,
    input  logic [W-1:0] count,
    output logic         at_last,
    output logic         wrap_clr
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    always_comb begin
        at_last  = (count == LAST);
        wrap_clr = at_last && step_taken(ctrl);
    end

    // R8
    mod_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (at_last && ctrl.clr_n && ctrl.load_n && ctrl.en_p && ctrl.en_t) |=> (count == '0));

    // R9
    mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (at_last && ctrl.clr_n && ctrl.load_n && !(ctrl.en_p && ctrl.en_t)) |=> (count == LAST));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int STAGES  = 2,
    parameter int STAGE_W = 4,
    parameter int MODULUS = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        cnt_en_p,
    input  logic                        cnt_en_t,
    input  logic [STAGES*STAGE_W-1:0]   load_val,
    output logic [STAGES*STAGE_W-1:0]   count,
    output logic                        carry_out
);

    localparam int TOT_W = STAGES * STAGE_W;

    logic [STAGES:0] t_chain;
    logic            eff_clr_n;
    cnt_ctrl_t       top_ctrl;

    always_comb begin
        top_ctrl.clr_n  = clr_n;
        top_ctrl.load_n = load_n;
        top_ctrl.en_p   = cnt_en_p;
        top_ctrl.en_t   = cnt_en_t;
    end

    assign t_chain[0] = cnt_en_t;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cnt_ctrl_t s_ctrl;
        always_comb begin
            s_ctrl.clr_n  = eff_clr_n;
            s_ctrl.load_n = load_n;
            s_ctrl.en_p   = cnt_en_p;
            s_ctrl.en_t   = t_chain[i];
        end
        cnt_stage #(.W(STAGE_W)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .ctrl (s_ctrl),
            .d    (load_val[i*STAGE_W +: STAGE_W]),
            .q    (count[i*STAGE_W +: STAGE_W]),
            .tc   (t_chain[i+1])
        );
    end

    if (MODULUS > 0) begin : g_mod
        logic at_last;
        logic wrap_clr;
        cnt_mod_detect #(.W(TOT_W), .MODULUS(MODULUS)) u_detect (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (top_ctrl),
            .count    (count),
            .at_last  (at_last),
            .wrap_clr (wrap_clr)
        );
        always_comb begin
            eff_clr_n = clr_n && !wrap_clr;
            carry_out = cnt_en_t && at_last;
        end
    end else begin : g_bin
        always_comb begin
            eff_clr_n = clr_n;
            carry_out = t_chain[STAGES];
        end

        // R7
        bin_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (step_taken(top_ctrl) && (&count)) |=> (count == '0));
    end

endmodule

// File: tb/cnt_chain_bench.sv
module cnt_chain_bench;

    localparam int W  = 8;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst, clr_n, load_n, en_p, en_t;
    logic [W-1:0]  load_val;
    logic [W-1:0]  count;
    logic [MW-1:0] count5, count11;
    logic          carry, carry5, carry11;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [W-1:0]  exp_b;
    logic [MW-1:0] exp_5, exp_11;
    string         tag_b, tag_5, tag_11;

    always #10 clk = ~clk;

    cnt_chain #(.STAGES(2), .STAGE_W(4), .MODULUS(0)) u_cnt_chain (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .load_val(load_val),
        .count(count), .carry_out(carry));

    cnt_chain #(.STAGES(1), .STAGE_W(4), .MODULUS(5)) u_cnt_chain_m5 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .load_val(load_val[MW-1:0]),
        .count(count5), .carry_out(carry5));

    cnt_chain #(.STAGES(1), .STAGE_W(4), .MODULUS(11)) u_cnt_chain_m11 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .load_val(load_val[MW-1:0]),
        .count(count11), .carry_out(carry11));

    function automatic logic [W-1:0] next_bin(input logic [W-1:0] cur);
        if (rst || !clr_n) return '0;
        if (!load_n)       return load_val;
        if (en_p && en_t)  return cur + W'(1);
        return cur;
    endfunction

    function automatic logic [MW-1:0] next_mod(input logic [MW-1:0] cur, input int n);
        if (rst || !clr_n) return '0;
        if (!load_n)       return load_val[MW-1:0];
        if (en_p && en_t)  return (cur == MW'(n - 1)) ? '0 : cur + MW'(1);
        return cur;
    endfunction

    function automatic string tag_for(input logic wrap_hit, input string wrap_tag);
        if (rst)          return "R1";
        if (!clr_n)       return "R2";
        if (!load_n)      return "R3";
        if (en_p && en_t) return wrap_hit ? wrap_tag : "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then drive the next inputs and advance the model.
    task automatic apply(input logic r, input logic c, input logic l,
                         input logic p, input logic t, input logic [W-1:0] d);
        @(negedge clk);
        check(tag_b,  int'(count),   int'(exp_b));
        check(tag_5,  int'(count5),  int'(exp_5));
        check(tag_11, int'(count11), int'(exp_11));
        check("R6", int'(carry),   int'(en_t && (exp_b == '1)));
        check("R8", int'(carry5),  int'(en_t && (exp_5 == MW'(4))));
        check("R8", int'(carry11), int'(en_t && (exp_11 == MW'(10))));
        rst = r; clr_n = c; load_n = l; en_p = p; en_t = t; load_val = d;
        tag_b  = tag_for(exp_b == '1, "R7");
        tag_5  = tag_for(exp_5 == MW'(4), "R8");
        tag_11 = tag_for(exp_11 == MW'(10), "R8");
        if (exp_5 >= MW'(5) || exp_11 >= MW'(11)) begin
            if (!rst && clr_n && load_n) begin
                tag_5  = (exp_5  >= MW'(5))  ? "R9" : tag_5;
                tag_11 = (exp_11 >= MW'(11)) ? "R9" : tag_11;
            end
        end
        if (!rst && clr_n && load_n && !(en_p && en_t)) begin
            if (exp_5 == MW'(4))   tag_5  = "R9";
            if (exp_11 == MW'(10)) tag_11 = "R9";
        end
        exp_b  = next_bin(exp_b);
        exp_5  = next_mod(exp_5, 5);
        exp_11 = next_mod(exp_11, 11);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0163));
        rst = 1; clr_n = 1; load_n = 1; en_p = 0; en_t = 0; load_val = '0;
        exp_b = '0; exp_5 = '0; exp_11 = '0;
        tag_b = "R1"; tag_5 = "R1"; tag_11 = "R1";
        @(posedge clk);
        // R1: reset state, with load and enables active
        apply(1, 1, 0, 1, 1, 8'hA5);
        apply(0, 1, 1, 0, 0, 8'h00);
        // R2 over load and enables
        apply(0, 1, 0, 1, 1, 8'h37);
        apply(0, 0, 0, 1, 1, 8'hFF);
        // R3 load 0xFC with enables low, then count through the wrap (R7)
        apply(0, 1, 0, 0, 0, 8'hFC);
        for (int k = 0; k < 6; k++) apply(0, 1, 1, 1, 1, 8'h00);
        // R5 hold with each enable low
        apply(0, 1, 1, 0, 1, 8'h00);
        apply(0, 1, 1, 1, 0, 8'h00);
        // R4 carry across the stage boundary
        apply(0, 1, 0, 1, 1, 8'h0F);
        apply(0, 1, 1, 1, 1, 8'h00);
        apply(0, 1, 1, 0, 0, 8'h00);
        // R6 combinational carry: load all ones, hold, toggle en_t between edges
        apply(0, 1, 0, 0, 0, 8'hFF);
        apply(0, 1, 1, 0, 1, 8'h00);
        @(negedge clk);
        en_t = 1'b0; #1;
        check("R6", int'(carry), 0);
        en_t = 1'b1; #1;
        check("R6", int'(carry), 1);
        // R8 modulus runs from zero
        apply(0, 0, 1, 0, 0, 8'h00);
        for (int k = 0; k < 24; k++) apply(0, 1, 1, 1, 1, 8'h00);
        // R9 hold at N-1, then load above N and count back around
        apply(0, 0, 1, 0, 0, 8'h00);
        for (int k = 0; k < 4; k++) apply(0, 1, 1, 1, 1, 8'h00);
        apply(0, 1, 1, 1, 0, 8'h00);
        apply(0, 1, 0, 1, 1, 8'h0C);
        for (int k = 0; k < 6; k++) apply(0, 1, 1, 1, 1, 8'h00);
        // Constrained random mix, priority reset > clear > load > count > hold
        for (int k = 0; k < 3000; k++) begin
            apply(($urandom % 64) == 0, ($urandom % 16) != 0, ($urandom % 8) != 0,
                  ($urandom % 4) != 0, ($urandom % 4) != 0, W'($urandom));
        end
        apply(0, 1, 1, 0, 0, 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule